// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a logical address, made of a 16-bit segment selector and a 32-bit offset, into a 32-bit linear address. The selector's index field locates an 8-byte descriptor, and its table flag chooses between a global and a local descriptor table. The block forms the descriptor's byte address from the chosen table base and fetches the descriptor through a 64-bit read port. The request side of that port uses a valid/ready handshake, and the response side returns a single valid beat.

The fetched descriptor holds its 32-bit base and 20-bit limit in split bit ranges, and the block rebuilds both. A granularity flag can scale the limit to 4 KiB units. The offset is checked against the scaled limit and then added to the base. A missing segment, a limit overrun and the null selector each end the translation with a fault code instead of an address.

The block handles one translation at a time. A caller presents a request while `req_ready` is high and watches `done`. The result stays on the outputs until the next `done` pulse.

Top module: `segx_translator`

## Requirements
- R1: The selector is split as index = bits 15..3, table flag = bit 2 and requested privilege = bits 1..0. A table flag of 0 selects `gdt_base` and a flag of 1 selects `ldt_base`. The requested privilege is returned on `seg_rpl`.
- R2: The descriptor byte address is the selected table base plus index × 8. It appears on `mem_req_addr` with `mem_req_valid` high, and both stay unchanged until `mem_req_ready` is sampled high.
- R3: The segment base is {descriptor[63:56], descriptor[39:16]}.
- R4: The raw limit is {descriptor[51:48], descriptor[15:0]}. When granularity (descriptor bit 55) is 1, the effective limit is raw × 4096 + 4095. When it is 0, the effective limit is the raw value.
- R5: An offset greater than the effective limit gives fault code 3 (limit) and a `lin_addr` of 0. An offset equal to the effective limit is accepted.
- R6: On success, `fault` is 0, `fault_code` is 0, and `lin_addr` = base + offset modulo 2^32.
- R7: A descriptor with bit 47 (present) clear gives fault code 2 (absent) and a `lin_addr` of 0. This fault takes precedence over a limit overrun.
- R8: A selector with index 0 and table flag 0 gives fault code 1 (null) and issues no memory read. `done` rises on the clock edge right after acceptance. A selector with index 0 and table flag 1 is not null.
- R9: A request is taken only when `req_valid` and `req_ready` are both high. While a fetch is outstanding, `busy` is 1 and `req_ready` is 0, and other requests are ignored. `done` marks each result for one cycle. All result outputs stay unchanged until the next `done`.
- R10: After reset, `busy`, `done`, `fault` and `mem_req_valid` are 0, `req_ready` is 1, and `lin_addr` is 0.
- R11: `seg_attr` = {descriptor[55:52], descriptor[47:40]}, so the descriptor privilege level is `seg_attr[6:5]` and the code/data-versus-system flag is `seg_attr[4]`. After a null fault, `seg_attr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_selector | input | 16 | Segment selector |
| req_offset | input | 32 | Offset within the segment |
| gdt_base | input | 32 | Global descriptor table base address |
| ldt_base | input | 32 | Local descriptor table base address |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 64 | 8-byte descriptor |
| busy | output | 1 | Translation in progress |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Result is a fault |
| fault_code | output | 2 | 0 none, 1 null, 2 absent, 3 limit |
| lin_addr | output | 32 | Linear address (0 on fault) |
| seg_attr | output | 12 | Descriptor attribute bits |
| seg_rpl | output | 2 | Requested privilege of the request |

## Verification
The bench builds the block with the package defaults: a 32-bit linear space, a 13-bit index and 8-byte descriptors. These widths are set by the descriptor format, so no other legal values exist to sweep. Within those defaults, the bench's memory model can stall the request handshake for any number of cycles and return data after a fixed latency. This exposes the held-address and busy-window behaviour, and it also exposes the limit boundary at both granularities, the absent-over-limit precedence and 32-bit wraparound of the sum.

// File: rtl/segx_pkg.sv
package segx_pkg;

    localparam int LIN_W      = 32;
    localparam int OFF_W      = 32;
    localparam int SEL_W      = 16;
    localparam int DESC_W     = 64;
    localparam int IDX_W      = SEL_W - 3;
    localparam int LIM_W      = 20;
    localparam int DESC_BYTES = 8;
    localparam int DESC_SHIFT = $clog2(DESC_BYTES);
    localparam int GRAN_SHIFT = LIN_W - LIM_W;
    localparam int ATTR_W     = 12;

    typedef struct packed {
        logic [IDX_W-1:0] index;
        logic             local_tbl;
        logic [1:0]       rpl;
    } selector_t;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_NULL   = 2'd1,
        FLT_ABSENT = 2'd2,
        FLT_LIMIT  = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ASK  = 2'd1,
        ST_WAIT = 2'd2
    } state_e;

    typedef struct packed {
        logic [LIN_W-1:0]  base;
        logic [LIN_W-1:0]  eff_limit;
        logic              present;
        logic [ATTR_W-1:0] attr;
    } seg_info_t;

    typedef struct packed {
        fault_e            code;
        logic [LIN_W-1:0]  lin;
        logic [ATTR_W-1:0] attr;
        logic [1:0]        rpl;
    } result_t;

    function automatic logic [LIN_W-1:0] gather_base(input logic [DESC_W-1:0] d);
        return {d[63:56], d[39:16]};
    endfunction

    function automatic logic [LIM_W-1:0] gather_limit(input logic [DESC_W-1:0] d);
        return {d[51:48], d[15:0]};
    endfunction

    function automatic logic [LIN_W-1:0] scale_limit(input logic [LIM_W-1:0] raw,
                                                     input logic             gran);
        if (gran)
            return {raw, {GRAN_SHIFT{1'b1}}};
        return {{GRAN_SHIFT{1'b0}}, raw};
    endfunction

endpackage

// File: rtl/segx_sel_decode.sv
module segx_sel_decode
    import segx_pkg::*;
(
    input  logic [SEL_W-1:0] selector,
    input  logic [LIN_W-1:0] gdt_base,
    input  logic [LIN_W-1:0] ldt_base,
    output logic [LIN_W-1:0] desc_addr,
    output logic             is_null,
    output logic [1:0]       rpl
);
    selector_t        sel;
    logic [LIN_W-1:0] tbl_base;
    logic [LIN_W-1:0] byte_off;

    always_comb begin
        sel       = selector_t'(selector);
        tbl_base  = sel.local_tbl ? ldt_base : gdt_base;
        byte_off  = LIN_W'(sel.index) << DESC_SHIFT;
        desc_addr = tbl_base + byte_off;
        is_null   = (sel.index == '0) && !sel.local_tbl;
        rpl       = sel.rpl;
    end
endmodule

// File: rtl/segx_desc_unpack.sv
module segx_desc_unpack
    import segx_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    output seg_info_t         info
);
    logic [LIM_W-1:0] raw_limit;
    logic             gran;

    always_comb begin
        raw_limit      = gather_limit(desc);
        gran           = desc[55];
        info.base      = gather_base(desc);
        info.eff_limit = scale_limit(raw_limit, gran);
        info.present   = desc[47];
        info.attr      = {desc[55:52], desc[47:40]};
    end
endmodule

// File: rtl/segx_limit_add.sv
module segx_limit_add
    import segx_pkg::*;
(
    input  seg_info_t        info,
    input  logic [OFF_W-1:0] offset,
    output fault_e           code,
    output logic [LIN_W-1:0] lin
);
    logic [LIN_W-1:0] sum;
    logic             over;

    always_comb begin
        sum  = info.base + LIN_W'(offset);
        over = LIN_W'(offset) > info.eff_limit;
        if (!info.present)
            code = FLT_ABSENT;
        else if (over)
            code = FLT_LIMIT;
        else
            code = FLT_NONE;
        lin = (code == FLT_NONE) ? sum : '0;
    end
endmodule

// File: rtl/segx_translator.sv
module segx_translator
    import segx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [SEL_W-1:0]    req_selector,
    input  logic [OFF_W-1:0]    req_offset,
    input  logic [LIN_W-1:0]    gdt_base,
    input  logic [LIN_W-1:0]    ldt_base,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [LIN_W-1:0]    mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [DESC_W-1:0]   mem_rsp_data,
    output logic                busy,
    output logic                done,
    output logic                fault,
    output logic [1:0]          fault_code,
    output logic [LIN_W-1:0]    lin_addr,
    output logic [ATTR_W-1:0]   seg_attr,
    output logic [1:0]          seg_rpl
);
    state_e           state;
    logic [LIN_W-1:0] addr_q;
    logic [OFF_W-1:0] offset_q;
    logic [1:0]       rpl_q;
    result_t          res_q;
    logic             done_q;

    logic [LIN_W-1:0] dec_addr;
    logic             dec_null;
    logic [1:0]       dec_rpl;
    seg_info_t        info;
    fault_e           chk_code;
    logic [LIN_W-1:0] chk_lin;
    logic             accept;

    segx_sel_decode u_dec (
        .selector  (req_selector),
        .gdt_base  (gdt_base),
        .ldt_base  (ldt_base),
        .desc_addr (dec_addr),
        .is_null   (dec_null),
        .rpl       (dec_rpl)
    );

    segx_desc_unpack u_unpack (
        .desc (mem_rsp_data),
        .info (info)
    );

    segx_limit_add u_check (
        .info   (info),
        .offset (offset_q),
        .code   (chk_code),
        .lin    (chk_lin)
    );

    assign accept = req_valid && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            addr_q   <= '0;
            offset_q <= '0;
            rpl_q    <= '0;
            done_q   <= 1'b0;
            res_q    <= '{code: FLT_NONE, lin: '0, attr: '0, rpl: '0};
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (dec_null) begin
                            done_q <= 1'b1;
                            res_q  <= '{code: FLT_NULL, lin: '0, attr: '0, rpl: dec_rpl};
                        end else begin
                            addr_q   <= dec_addr;
                            offset_q <= req_offset;
                            rpl_q    <= dec_rpl;
                            state    <= ST_ASK;
                        end
                    end
                end
                ST_ASK: begin
                    if (mem_req_ready)
                        state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        done_q <= 1'b1;
                        res_q  <= '{code: chk_code, lin: chk_lin, attr: info.attr, rpl: rpl_q};
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign busy          = (state != ST_IDLE);
    assign mem_req_valid = (state == ST_ASK);
    assign mem_req_addr  = addr_q;
    assign done          = done_q;
    assign fault_code    = res_q.code;
    assign fault         = (res_q.code != FLT_NONE);
    assign lin_addr      = res_q.lin;
    assign seg_attr      = res_q.attr;
    assign seg_rpl       = res_q.rpl;

    // R2: address and valid hold while the memory stalls
    a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R8: null selector finishes at once without a read
    a_r8_null_no_read: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && (req_selector[SEL_W-1:2] == '0)
        |=> done && (fault_code == FLT_NULL) && !mem_req_valid);

    // R9: an accepted request is either in flight or finished next cycle
    a_r9_accept_tracked: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> busy || done);

    // R9: results change only together with done
    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        done || ($stable(lin_addr) && $stable(fault_code) && $stable(seg_attr)));

    // R5, R7: a faulting result never carries an address
    a_r7_fault_no_addr: assert property (@(posedge clk) disable iff (rst)
        done && fault |-> lin_addr == '0);

endmodule

// File: tb/segx_translator_tb_top.sv
module segx_translator_tb_top;
    import segx_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_selector = '0;
    logic [31:0] req_offset = '0;
    logic [31:0] gdt_base = 32'h0001_0000;
    logic [31:0] ldt_base = 32'h0002_0000;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        busy, done, fault;
    logic [1:0]  fault_code;
    logic [31:0] lin_addr;
    logic [11:0] seg_attr;
    logic [1:0]  seg_rpl;

    int vectors = 0;
    int misses  = 0;
    int reads   = 0;
    int cycles  = 0;
    logic        ready_en = 1'b1;
    logic [31:0] last_addr = '0;
    logic        pend = 1'b0;
    logic [1:0]  lat = '0;
    logic [31:0] pend_addr = '0;
    logic [31:0] mem_a [8];
    logic [63:0] mem_d [8];

    always #5 clk = ~clk;
    assign mem_req_ready = ready_en;

    segx_translator dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_selector(req_selector), .req_offset(req_offset),
        .gdt_base(gdt_base), .ldt_base(ldt_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .busy(busy), .done(done), .fault(fault),
        .fault_code(fault_code), .lin_addr(lin_addr), .seg_attr(seg_attr),
        .seg_rpl(seg_rpl)
    );

    function automatic logic [63:0] lookup(input logic [31:0] a);
        for (int i = 0; i < 8; i++)
            if (mem_a[i] == a) return mem_d[i];
        return 64'h0;
    endfunction

    // memory model: accepts a request, answers two cycles later
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            pend      <= 1'b1;
            lat       <= 2'd1;
            pend_addr <= mem_req_addr;
            last_addr <= mem_req_addr;
            reads     <= reads + 1;
        end else if (pend) begin
            if (lat == 0) begin
                pend          <= 1'b0;
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= lookup(pend_addr);
            end else begin
                lat <= lat - 1;
            end
        end
    end

    function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
                                             input logic g, input logic p,
                                             input logic [1:0] dpl, input logic s);
        logic [63:0] d = '0;
        d[15:0]  = lim[15:0];
        d[39:16] = base[23:0];
        d[44]    = s;
        d[46:45] = dpl;
        d[47]    = p;
        d[51:48] = lim[19:16];
        d[55]    = g;
        d[63:56] = base[31:24];
        return d;
    endfunction

    function automatic logic [15:0] mk_sel(input int idx, input logic ti, input logic [1:0] rpl);
        return {13'(idx), ti, rpl};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] sel, input logic [31:0] off);
        @(negedge clk);
        req_valid    = 1'b1;
        req_selector = sel;
        req_offset   = off;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        for (int k = 0; k < 64; k++) begin
            if (done) return;
            @(negedge clk);
        end
        check(1'b0, {tag, " done timeout"}, 0, 1);
    endtask

    task automatic expect_res(input string tag, input logic [1:0] code,
                              input logic [31:0] lin, input logic [11:0] attr,
                              input logic [1:0] rpl);
        check(done == 1'b1, {tag, " done"}, done, 1);
        check(fault_code == code, {tag, " code"}, fault_code, code);
        check(fault == (code != 0), {tag, " fault"}, fault, code != 0);
        check(lin_addr == lin, {tag, " lin"}, lin_addr, lin);
        check(seg_attr == attr, {tag, " attr"}, seg_attr, attr);
        check(seg_rpl == rpl, {tag, " rpl"}, seg_rpl, rpl);
    endtask

    function automatic logic [11:0] attr_of(input logic [63:0] d);
        return {d[55:52], d[47:40]};
    endfunction

    task automatic t_reset();
        check(busy == 0, "R10 busy", busy, 0);
        check(done == 0, "R10 done", done, 0);
        check(fault == 0, "R10 fault", fault, 0);
        check(mem_req_valid == 0, "R10 mem_req_valid", mem_req_valid, 0);
        check(req_ready == 1, "R10 req_ready", req_ready, 1);
        check(lin_addr == 0, "R10 lin", lin_addr, 0);
    endtask

    task automatic t_global();
        logic [63:0] d = mk_desc(32'h1234_5678, 20'hFFFFF, 0, 1, 2'd0, 1);
        mem_a[0] = gdt_base + 32'd40; mem_d[0] = d;
        send(mk_sel(5, 0, 2'd1), 32'h100);
        wait_done("R6");
        check(last_addr == gdt_base + 32'd40, "R1 R2 global desc addr", last_addr, gdt_base + 40);
        expect_res("R3 R6 R11 global", 2'd0, 32'h1234_5778, attr_of(d), 2'd1);
        check(seg_attr[6:5] == 2'd0 && seg_attr[4] == 1'b1, "R11 dpl/s", seg_attr, attr_of(d));
    endtask

    task automatic t_local_bounds();
        logic [63:0] d = mk_desc(32'hA0B0_C0D0, 20'h00FFF, 0, 1, 2'd3, 1);
        mem_a[1] = ldt_base + 32'd24; mem_d[1] = d;
        send(mk_sel(3, 1, 2'd3), 32'hFFF);
        wait_done("R5");
        check(last_addr == ldt_base + 32'd24, "R1 R2 local desc addr", last_addr, ldt_base + 24);
        expect_res("R5 at limit", 2'd0, 32'hA0B0_C0D0 + 32'hFFF, attr_of(d), 2'd3);
        send(mk_sel(3, 1, 2'd3), 32'h1000);
        wait_done("R5");
        expect_res("R5 over limit", 2'd3, 32'h0, attr_of(d), 2'd3);
    endtask

    task automatic t_gran();
        logic [63:0] d = mk_desc(32'h0040_0000, 20'h00002, 1, 1, 2'd0, 1);
        mem_a[2] = gdt_base + 32'd56; mem_d[2] = d;
        send(mk_sel(7, 0, 2'd0), 32'h2FFF);
        wait_done("R4");
        expect_res("R4 gran top", 2'd0, 32'h0040_2FFF, attr_of(d), 2'd0);
        check(seg_attr[11] == 1'b1, "R11 gran bit", seg_attr[11], 1);
        send(mk_sel(7, 0, 2'd0), 32'h3000);
        wait_done("R4");
        expect_res("R4 R5 gran over", 2'd3, 32'h0, attr_of(d), 2'd0);
    endtask

    task automatic t_absent();
        logic [63:0] d = mk_desc(32'h5000_0000, 20'h00010, 0, 0, 2'd2, 0);
        mem_a[3] = gdt_base + 32'd72; mem_d[3] = d;
        send(mk_sel(9, 0, 2'd0), 32'h4);
        wait_done("R7");
        expect_res("R7 absent", 2'd2, 32'h0, attr_of(d), 2'd0);
        send(mk_sel(9, 0, 2'd0), 32'h20);
        wait_done("R7");
        expect_res("R7 absent over limit", 2'd2, 32'h0, attr_of(d), 2'd0);
    endtask

    task automatic t_null();
        int r0 = reads;
        send(mk_sel(0, 0, 2'd3), 32'h10);
        check(done == 1'b1, "R8 done next edge", done, 1);
        expect_res("R8 null", 2'd1, 32'h0, 12'h0, 2'd3);
        repeat (4) @(negedge clk);
        check(reads == r0, "R8 no read", reads, r0);
    endtask

    task automatic t_local_zero();
        logic [63:0] d = mk_desc(32'h0000_0100, 20'h00010, 0, 1, 2'd1, 1);
        mem_a[4] = ldt_base; mem_d[4] = d;
        send(mk_sel(0, 1, 2'd0), 32'h10);
        wait_done("R8");
        check(last_addr == ldt_base, "R8 local index0 read", last_addr, ldt_base);
        expect_res("R8 local index0", 2'd0, 32'h110, attr_of(d), 2'd0);
    endtask

    task automatic t_wrap();
        logic [63:0] d = mk_desc(32'hFFFF_F000, 20'hFFFFF, 1, 1, 2'd0, 1);
        mem_a[5] = gdt_base + 32'd80; mem_d[5] = d;
        send(mk_sel(10, 0, 2'd0), 32'h1800);
        wait_done("R6");
        expect_res("R6 wrap", 2'd0, 32'h0000_0800, attr_of(d), 2'd0);
    endtask

    task automatic t_stall();
        int r0 = reads;
        ready_en = 1'b0;
        send(mk_sel(5, 0, 2'd2), 32'h8);
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R9 busy in stall", busy, 1);
        check(req_ready == 1'b0, "R9 not ready", req_ready, 0);
        check(mem_req_valid == 1'b1, "R2 valid held", mem_req_valid, 1);
        check(mem_req_addr == gdt_base + 32'd40, "R2 addr held", mem_req_addr, gdt_base + 40);
        req_valid = 1'b1; req_selector = mk_sel(0, 0, 2'd0);
        @(negedge clk);
        req_valid = 1'b0;
        check(done == 1'b0, "R9 ignored while busy", done, 0);
        ready_en = 1'b1;
        wait_done("R9");
        expect_res("R9 stalled result", 2'd0, 32'h1234_5680, attr_of(mem_d[0]), 2'd2);
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R9 single done", done, 0);
        check(lin_addr == 32'h1234_5680, "R9 result held", lin_addr, 32'h1234_5680);
        check(reads == r0 + 1, "R9 one read", reads, r0 + 1);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin mem_a[i] = 32'hFFFF_FFFF; mem_d[i] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_global();
        t_local_bounds();
        t_gran();
        t_absent();
        t_null();
        t_local_zero();
        t_wrap();
        t_stall();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            vectors++;
            misses++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule